// File: doc/BRIEF.md
# Favorite-Memory Request Traffic Generator

This block produces synthetic memory-request traffic for exercising a processor-to-memory interconnect. It models `NUM_PROC` processors and `NUM_MEM` memory modules. In every clock cycle each processor independently decides whether to issue a request. When it does, it picks a target memory from a biased distribution. Processor i prefers memory i, which is its favorite. It spreads whatever probability is left evenly over the remaining memories.

Two threshold inputs set the traffic. `req_prob` sets how often a processor requests. `fav_prob` sets how strongly a processor sticks to its favorite. Each processor draws its random numbers from its own linear-feedback shift register, started from its own seed. No processor's draws depend on what happened to earlier requests. A request that an arbiter downstream turns away is simply dropped, and the generator never issues it again.

Processors with no memory of the same index address all memories uniformly. Memories with no processor of the same index are reached only through the uniform share. A side output reports, for the current cycle, how many different memories are being asked for.

Top module: `favmem_traffic_gen`

## Requirements
- R1: While `rst_n` is low, `req_valid`, `req_target` and `distinct_cnt` are all zero.
- R2: In each cycle a processor requests when its fresh 16-bit draw is strictly below `req_prob`, a 17-bit value from 0 to 65536. A setting of 0 therefore gives no requests, and 65536 makes every processor request every cycle. A setting sampled at one clock edge shows on the outputs right after that edge.
- R3: `req_target` holds processor i's memory index in bits [i*IDX_W +: IDX_W], with IDX_W = clog2(NUM_MEM). Whenever processor i is valid, that index is below `NUM_MEM`.
- R4: With `fav_prob` = 65536, every valid processor i with i < NUM_MEM targets memory i.
- R5: With `fav_prob` = 0, a processor i with i < NUM_MEM never targets memory i, yet it reaches every other memory.
- R6: A processor i with i >= NUM_MEM addresses each of the NUM_MEM memories with probability 1/NUM_MEM, whatever `fav_prob` is.
- R7: Over a long run, each processor's request rate is within tolerance of req_prob/65536.
- R8: Over a long run, the fraction of a paired processor's requests that go to its favorite is close to m = fav_prob/65536. Each other memory receives close to (1-m)/(NUM_MEM-1). With fav_prob = 65536/NUM_MEM, addressing is uniform.
- R9: In every cycle, `distinct_cnt` equals the number of memories that receive at least one valid request in that same cycle.
- R10: The processors draw independently. With a request rate of 1/4, two processors disagree on requesting in well over a quarter of the cycles (about 3/8 is expected).
- R11: When NUM_PROC < NUM_MEM, memories with an index at or above NUM_PROC receive no requests under fav_prob = 65536. Under other settings they receive about (1-m)/(NUM_MEM-1) of each paired processor's requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_prob | input | PROB_W+1 | Request threshold out of 2^PROB_W |
| fav_prob | input | PROB_W+1 | Favorite-target threshold out of 2^PROB_W |
| req_valid | output | NUM_PROC | Per-processor request flag |
| req_target | output | NUM_PROC*IDX_W | Per-processor memory index, packed |
| distinct_cnt | output | clog2(NUM_MEM+1) | Number of distinct memories requested this cycle |

## Verification
The bench drives several threshold settings, and each one isolates a different behaviour:
- Requests switched fully off, and requests at certainty, pin down the threshold comparison exactly.
- Certainty paired with a locked favorite, and then with a forbidden favorite, tells the favorite path apart from the skip-over mapping. This includes reaching every non-favorite memory.
- A quarter request rate with a 0.8 favorite weight gives long-run rates that separate the request draw, the favorite draw and the index draw. It also shows whether processors share random state.
- Saturated traffic at m = 1/N checks the uniform case.
- A second instance with fewer processors than memories shows the unpaired memories fed only through the uniform share.

// File: rtl/fmg_pkg.sv
package fmg_pkg;

   typedef enum logic {
      FMG_FAVORED,
      FMG_UNIFORM
   } fmg_addr_mode_e;

   // Feedback tap mask for a maximal-length shift register of width w.
   function automatic logic [63:0] fmg_tap_mask(input int unsigned w);
      logic [63:0] m;
      m = '0;
      case (w)
         32: begin m[31] = 1'b1; m[21] = 1'b1; m[1]  = 1'b1; m[0]  = 1'b1; end
         48: begin m[47] = 1'b1; m[46] = 1'b1; m[20] = 1'b1; m[19] = 1'b1; end
         64: begin m[63] = 1'b1; m[62] = 1'b1; m[60] = 1'b1; m[59] = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction

   // Distinct nonzero start value per generator lane.
   function automatic logic [63:0] fmg_seed(input int unsigned idx, input int unsigned w);
      return 64'h6A09E667F3BCC909 ^ (64'(idx) << (w - 16));
   endfunction

endpackage

// File: rtl/fmg_lfsr.sv
module fmg_lfsr
   import fmg_pkg::*;
#(
   parameter int unsigned       LFSR_W = 64,
   parameter int unsigned       STEPS  = 48,
   parameter logic [LFSR_W-1:0] SEED   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [STEPS-1:0] fresh
);

   localparam logic [63:0]       TAP_ALL = fmg_tap_mask(LFSR_W);
   localparam logic [LFSR_W-1:0] TAPS    = TAP_ALL[LFSR_W-1:0];

   if (STEPS > LFSR_W || STEPS < 1) begin : g_bad_steps
      $error("fmg_lfsr: STEPS must lie in 1..LFSR_W");
   end
   if (TAPS == '0) begin : g_bad_width
      $error("fmg_lfsr: unsupported LFSR_W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("fmg_lfsr: seed must be nonzero");
   end

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] state_nxt;

   // Jump STEPS shifts per cycle so every output bit is new each cycle.
   always_comb begin
      state_nxt = state_q;
      for (int s = 0; s < STEPS; s++) begin
         state_nxt = {state_nxt[LFSR_W-2:0], ^(state_nxt & TAPS)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= state_nxt;
   end

   assign fresh = state_nxt[STEPS-1:0];

endmodule

// File: rtl/fmg_target_pick.sv
module fmg_target_pick
   import fmg_pkg::*;
#(
   parameter int unsigned  NUM_MEM  = 4,
   parameter int unsigned  DRAW_W   = 16,
   parameter int unsigned  PROC_IDX = 0,
   parameter bit           HAS_FAV  = 1'b1,
   localparam int unsigned IDX_W    = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1,
   localparam int unsigned THR_W    = DRAW_W + 1
) (
   input  logic [DRAW_W-1:0] draw_req,
   input  logic [DRAW_W-1:0] draw_fav,
   input  logic [DRAW_W-1:0] draw_idx,
   input  logic [THR_W-1:0]  req_thr,
   input  logic [THR_W-1:0]  fav_thr,
   output logic              want,
   output logic [IDX_W-1:0]  target
);

   localparam int unsigned    PROD_W = DRAW_W + IDX_W + 1;
   localparam fmg_addr_mode_e MODE   = (HAS_FAV && NUM_MEM > 1) ? FMG_FAVORED : FMG_UNIFORM;

   if (HAS_FAV && PROC_IDX >= NUM_MEM) begin : g_bad_idx
      $error("fmg_target_pick: favorite index out of range");
   end

   // Map a uniform draw onto 0..span-1 by fixed-point scaling.
   function automatic logic [IDX_W-1:0] scale_draw(input logic [DRAW_W-1:0] d,
                                                    input int unsigned     span);
      logic [PROD_W-1:0] prod;
      prod = PROD_W'(d) * PROD_W'(span);
      return IDX_W'(prod >> DRAW_W);
   endfunction

   assign want = ({1'b0, draw_req} < req_thr);

   if (NUM_MEM == 1) begin : g_single
      logic unused_single;
      assign unused_single = ^{draw_fav, draw_idx, fav_thr};
      assign target = '0;
   end else if (MODE == FMG_FAVORED) begin : g_favored
      logic             hit_fav;
      logic [IDX_W-1:0] other;
      assign hit_fav = ({1'b0, draw_fav} < fav_thr);
      assign other   = scale_draw(draw_idx, NUM_MEM - 1);
      // Skip over the favorite so the N-1 others share the remainder evenly.
      always_comb begin
         if (hit_fav)                        target = IDX_W'(PROC_IDX);
         else if (other >= IDX_W'(PROC_IDX)) target = other + 1'b1;
         else                                target = other;
      end
   end else begin : g_uniform
      logic unused_uniform;
      assign unused_uniform = ^{draw_fav, fav_thr};
      assign target = scale_draw(draw_idx, NUM_MEM);
   end

endmodule

// File: rtl/fmg_distinct_count.sv
module fmg_distinct_count #(
   parameter int unsigned  NUM_PROC = 6,
   parameter int unsigned  NUM_MEM  = 4,
   localparam int unsigned IDX_W    = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1,
   localparam int unsigned CNT_W    = $clog2(NUM_MEM + 1)
) (
   input  logic [NUM_PROC-1:0]       valid,
   input  logic [NUM_PROC*IDX_W-1:0] targets,
   output logic [CNT_W-1:0]          count
);

   logic [NUM_MEM-1:0] touched;

   for (genvar j = 0; j < NUM_MEM; j++) begin : g_mem
      logic [NUM_PROC-1:0] hits;
      for (genvar p = 0; p < NUM_PROC; p++) begin : g_src
         assign hits[p] = valid[p] && (targets[p*IDX_W +: IDX_W] == IDX_W'(j));
      end
      assign touched[j] = |hits;
   end

   always_comb begin
      count = '0;
      for (int j = 0; j < NUM_MEM; j++) begin
         count = count + CNT_W'(touched[j]);
      end
   end

endmodule

// File: rtl/favmem_traffic_gen.sv
module favmem_traffic_gen
   import fmg_pkg::*;
#(
   parameter int unsigned  NUM_PROC = 6,
   parameter int unsigned  NUM_MEM  = 4,
   parameter int unsigned  PROB_W   = 16,
   parameter int unsigned  LFSR_W   = 64,
   localparam int unsigned THR_W    = PROB_W + 1,
   localparam int unsigned IDX_W    = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1,
   localparam int unsigned CNT_W    = $clog2(NUM_MEM + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [THR_W-1:0]          req_prob,
   input  logic [THR_W-1:0]          fav_prob,
   output logic [NUM_PROC-1:0]       req_valid,
   output logic [NUM_PROC*IDX_W-1:0] req_target,
   output logic [CNT_W-1:0]          distinct_cnt
);

   localparam int unsigned DRAW_STEPS = 3 * PROB_W;

   if (NUM_PROC < 1 || NUM_MEM < 1) begin : g_bad_size
      $error("favmem_traffic_gen: need at least one processor and one memory");
   end
   if (PROB_W < 4 || DRAW_STEPS > LFSR_W) begin : g_bad_draw
      $error("favmem_traffic_gen: three draws of PROB_W bits must fit in LFSR_W");
   end
   if (NUM_PROC > (1 << (LFSR_W - 16 < 16 ? LFSR_W - 16 : 16))) begin : g_bad_seeds
      $error("favmem_traffic_gen: too many processors for distinct seeds");
   end

   logic [NUM_PROC-1:0]       want_d;
   logic [NUM_PROC*IDX_W-1:0] target_d;

   for (genvar i = 0; i < NUM_PROC; i++) begin : g_proc
      localparam logic [63:0] SEED_ALL = fmg_seed(i, LFSR_W);
      logic [DRAW_STEPS-1:0] fresh;

      fmg_lfsr #(
         .LFSR_W (LFSR_W),
         .STEPS  (DRAW_STEPS),
         .SEED   (SEED_ALL[LFSR_W-1:0])
      ) u_rng (
         .clk   (clk),
         .rst_n (rst_n),
         .fresh (fresh)
      );

      fmg_target_pick #(
         .NUM_MEM  (NUM_MEM),
         .DRAW_W   (PROB_W),
         .PROC_IDX (i),
         .HAS_FAV  (i < NUM_MEM)
      ) u_pick (
         .draw_req (fresh[PROB_W-1:0]),
         .draw_fav (fresh[2*PROB_W-1:PROB_W]),
         .draw_idx (fresh[3*PROB_W-1:2*PROB_W]),
         .req_thr  (req_prob),
         .fav_thr  (fav_prob),
         .want     (want_d[i]),
         .target   (target_d[i*IDX_W +: IDX_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid  <= '0;
         req_target <= '0;
      end else begin
         req_valid  <= want_d;
         req_target <= target_d;
      end
   end

   fmg_distinct_count #(
      .NUM_PROC (NUM_PROC),
      .NUM_MEM  (NUM_MEM)
   ) u_count (
      .valid   (req_valid),
      .targets (req_target),
      .count   (distinct_cnt)
   );

endmodule

// File: rtl/fmg_checker.sv
module fmg_checker #(
   parameter int unsigned  NUM_PROC = 6,
   parameter int unsigned  NUM_MEM  = 4,
   parameter int unsigned  PROB_W   = 16,
   localparam int unsigned THR_W    = PROB_W + 1,
   localparam int unsigned IDX_W    = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1,
   localparam int unsigned CNT_W    = $clog2(NUM_MEM + 1)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [THR_W-1:0]          req_prob,
   input logic [THR_W-1:0]          fav_prob,
   input logic [NUM_PROC-1:0]       req_valid,
   input logic [NUM_PROC*IDX_W-1:0] req_target,
   input logic [CNT_W-1:0]          distinct_cnt
);

   localparam logic [THR_W-1:0] FULL = THR_W'(1) << PROB_W;

   p_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_prob == '0) |=> (req_valid == '0));

   p_all_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_prob == FULL) |=> (&req_valid));

   p_distinct_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (distinct_cnt <= $countones(req_valid)) && ((distinct_cnt == '0) == (req_valid == '0)));

   p_distinct_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      distinct_cnt <= NUM_MEM);

   for (genvar i = 0; i < NUM_PROC; i++) begin : g_lane
      p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid[i] |-> (req_target[i*IDX_W +: IDX_W] < NUM_MEM));
      if (i < NUM_MEM) begin : g_paired
         p_fav_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_prob == FULL && fav_prob == FULL) |=> (req_target[i*IDX_W +: IDX_W] == IDX_W'(i)));
         p_fav_avoid_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (fav_prob == '0) |=> !(req_valid[i] && req_target[i*IDX_W +: IDX_W] == IDX_W'(i)));
      end
   end

endmodule

bind favmem_traffic_gen fmg_checker #(
   .NUM_PROC (NUM_PROC),
   .NUM_MEM  (NUM_MEM),
   .PROB_W   (PROB_W)
) u_fmg_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_prob     (req_prob),
   .fav_prob     (fav_prob),
   .req_valid    (req_valid),
   .req_target   (req_target),
   .distinct_cnt (distinct_cnt)
);

// File: tb/favmem_traffic_gen_test.sv
module favmem_traffic_gen_test;

   localparam int M = 6, N = 4, IW = 2, CW = 3;     // main instance
   localparam int MS = 3, NS = 5, IWS = 3, CWS = 3; // fewer processors than memories
   localparam logic [16:0] FULL = 17'h10000;

   typedef struct packed {
      logic none;
      logic all;
      logic lock;
      logic avoid;
   } expect_t;

   localparam expect_t E_IDLE   = '{none: 1'b1, all: 1'b0, lock: 1'b0, avoid: 1'b0};
   localparam expect_t E_LOCK   = '{none: 1'b0, all: 1'b1, lock: 1'b1, avoid: 1'b0};
   localparam expect_t E_AVOID  = '{none: 1'b0, all: 1'b1, lock: 1'b0, avoid: 1'b1};
   localparam expect_t E_FREE   = '{none: 1'b0, all: 1'b0, lock: 1'b0, avoid: 1'b0};
   localparam expect_t E_SATUR  = '{none: 1'b0, all: 1'b1, lock: 1'b0, avoid: 1'b0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [16:0] req_prob = '0;
   logic [16:0] fav_prob = '0;
   logic [M-1:0]      vw;
   logic [M*IW-1:0]   tw;
   logic [CW-1:0]     dw;
   logic [MS-1:0]     vs;
   logic [MS*IWS-1:0] ts;
   logic [CWS-1:0]    ds;

   always #4ns clk = ~clk;   // 125 MHz

   favmem_traffic_gen uut (
      .clk(clk), .rst_n(rst_n), .req_prob(req_prob), .fav_prob(fav_prob),
      .req_valid(vw), .req_target(tw), .distinct_cnt(dw));

   favmem_traffic_gen #(.NUM_PROC(MS), .NUM_MEM(NS)) uut_small (
      .clk(clk), .rst_n(rst_n), .req_prob(req_prob), .fav_prob(fav_prob),
      .req_valid(vs), .req_target(ts), .distinct_cnt(ds));

   expect_t sb_q[$];
   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   longint cyc;
   longint diff01;
   longint n_req[M];
   longint hist[M][N];
   longint n_req_s[MS];
   longint hist_s[MS][NS];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic near(input string req, input string what, input longint num,
                       input longint den, input longint exp_pm, input longint tol_pm);
      longint pm;
      pm = (den > 0) ? (num * 1000) / den : -1;
      check(den > 0 && pm >= exp_pm - tol_pm && pm <= exp_pm + tol_pm, req, what, pm, exp_pm);
   endtask

   task automatic clear_stats();
      cyc = 0; diff01 = 0;
      for (int i = 0; i < M; i++) begin
         n_req[i] = 0;
         for (int j = 0; j < N; j++) hist[i][j] = 0;
      end
      for (int i = 0; i < MS; i++) begin
         n_req_s[i] = 0;
         for (int j = 0; j < NS; j++) hist_s[i][j] = 0;
      end
   endtask

   // Driver: apply a setting and queue one expectation per cycle.
   task automatic drive(input logic [16:0] rp, input logic [16:0] fp,
                        input expect_t e, input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         req_prob = rp;
         fav_prob = fp;
         sb_q.push_back(e);
      end
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic score(input expect_t e);
      bit ok, ok_lock, ok_avoid;
      int t;
      logic [N-1:0]  seen;
      logic [NS-1:0] seen_s;
      seen = '0; seen_s = '0; ok = 1'b1; ok_lock = 1'b1; ok_avoid = 1'b1;
      for (int i = 0; i < M; i++) begin
         t = int'(tw[i*IW +: IW]);
         if (vw[i]) begin
            if (t >= N) ok = 1'b0; else seen[t] = 1'b1;
            if (i < N && t == i) ok_avoid = 1'b0;
         end
         if (i < N && t != i) ok_lock = 1'b0;
      end
      for (int i = 0; i < MS; i++) begin
         t = int'(ts[i*IWS +: IWS]);
         if (vs[i]) begin
            if (t >= NS) ok = 1'b0; else seen_s[t] = 1'b1;
            if (t == i) ok_avoid = 1'b0;
         end
         if (t != i) ok_lock = 1'b0;
      end
      check(ok, "R3", "target index in range", {ts, tw}, 0);
      check(int'(dw) == $countones(seen), "R9", "distinct count main", dw, $countones(seen));
      check(int'(ds) == $countones(seen_s), "R9", "distinct count small", ds, $countones(seen_s));
      if (e.none) check(vw == '0 && vs == '0, "R2", "no requests at zero", {vs, vw}, 0);
      if (e.all)  check(&vw && &vs, "R2", "all request at full", {vs, vw}, {MS+M{1'b1}});
      if (e.lock) check(ok_lock, "R4", "favorite locked", {ts, tw[N*IW-1:0]}, {9'b010_001_000, 8'b11_10_01_00});
      if (e.avoid) check(ok_avoid, "R5", "favorite never chosen", {ts, tw}, 0);
      cyc++;
      if (vw[0] != vw[1]) diff01++;
      for (int i = 0; i < M; i++) if (vw[i]) begin
         n_req[i]++;
         t = int'(tw[i*IW +: IW]);
         if (t < N) hist[i][t]++;
      end
      for (int i = 0; i < MS; i++) if (vs[i]) begin
         n_req_s[i]++;
         t = int'(ts[i*IWS +: IWS]);
         if (t < NS) hist_s[i][t]++;
      end
   endtask

   // Monitor: pop and compare just after each active edge.
   initial begin
      forever begin
         @(posedge clk);
         #2ns;
         if (rst_n && sb_q.size() > 0) score(sb_q.pop_front());
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   initial begin
      clear_stats();
      repeat (3) @(posedge clk);
      #2ns;
      // R1: reset state
      check(vw == '0 && vs == '0, "R1", "valid in reset", {vs, vw}, 0);
      check(tw == '0 && ts == '0, "R1", "target in reset", {ts, tw}, 0);
      check(dw == '0 && ds == '0, "R1", "distinct in reset", {ds, dw}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      drive(17'd0, FULL, E_IDLE, 40);                   // R2 off

      clear_stats();
      drive(FULL, FULL, E_LOCK, 200);                   // R2 full, R4 locked
      check(hist_s[0][3] + hist_s[0][4] + hist_s[1][3] + hist_s[1][4] + hist_s[2][3] + hist_s[2][4] == 0,
            "R11", "unpaired memories idle under locked favorite",
            hist_s[0][3] + hist_s[1][3] + hist_s[2][3] + hist_s[0][4] + hist_s[1][4] + hist_s[2][4], 0);
      for (int i = N; i < M; i++) begin
         longint hits0;
         hits0 = 0;
         for (int j = 0; j < N; j++) if (hist[i][j] > 0) hits0++;
         check(hits0 == N, "R6", "unpaired processor spans all memories", hits0, N);
      end

      clear_stats();
      drive(FULL, 17'd0, E_AVOID, 400);                 // R5 forbidden favorite
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) if (j != i)
         check(hist[i][j] > 0, "R5", $sformatf("proc %0d reaches mem %0d", i, j), hist[i][j], 1);
      for (int i = 0; i < MS; i++) for (int j = MS; j < NS; j++)
         check(hist_s[i][j] > 0, "R11", $sformatf("small proc %0d reaches mem %0d", i, j), hist_s[i][j], 1);

      clear_stats();
      drive(17'd16384, 17'd52429, E_FREE, 8000);        // p = 0.25, m = 0.8
      for (int i = 0; i < M; i++)
         near("R7", $sformatf("request rate proc %0d", i), n_req[i], cyc, 250, 30);
      for (int i = 0; i < N; i++) begin
         near("R8", $sformatf("favorite share proc %0d", i), hist[i][i], n_req[i], 800, 40);
         for (int j = 0; j < N; j++) if (j != i)
            near("R8", $sformatf("other share proc %0d mem %0d", i, j), hist[i][j], n_req[i], 67, 30);
      end
      for (int i = N; i < M; i++) for (int j = 0; j < N; j++)
         near("R6", $sformatf("uniform share proc %0d mem %0d", i, j), hist[i][j], n_req[i], 250, 50);
      for (int j = MS; j < NS; j++)
         near("R11", $sformatf("small mem %0d share of proc 0", j), hist_s[0][j], n_req_s[0], 50, 30);
      near("R10", "proc 0 and 1 disagree", diff01, cyc, 375, 100);

      clear_stats();
      drive(FULL, 17'd16384, E_SATUR, 4000);            // m = 1/N uniform
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
         near("R8", $sformatf("uniform at m=1/N proc %0d mem %0d", i, j), hist[i][j], n_req[i], 250, 40);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #1ms;
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule